// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the lock reservations that pair a load-linked access with a later store-conditional. Each reservation names a cache line and the requester that placed it. The block is evaluated once for each completed memory operation. The completion gives an operation type, a line address, a requester id and a flag that says whether the line's tag is present in the cache. The block updates its reservation table and returns a one-bit result to the processor: 1 for success, 0 for failure.

Reservations sit in a small table. Each entry holds a line address, an owner id and a valid bit, and there is at most one entry per line. When the table is full, a new lock evicts the entry that was allocated earliest. A bypass input turns all reservation processing off and forces success. This is meant for traffic generators that do not follow the lock protocol. The result and the updated table take effect in the cycle after the completion strobe, together with a one-cycle done pulse.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked completion (op_i = 2) reserves line_i for req_id_i, and its result is success (1).
- R2: A store-conditional completion (op_i = 3) reports 1 when line_i is reserved by the same req_id_i, and reports 0 in every other case.
- R3: Every store-conditional removes the reservation on its line, whether it succeeds or fails and whichever id owns it.
- R4: An ordinary write completion (op_i = 1) removes the reservation only when tag_hit_i is 1 and the line is reserved by the same req_id_i. In every other case the table is unchanged. Its result is always 1.
- R5: A read completion (op_i = 0) never changes the table, and its result is 1.
- R6: While bypass_i is 1 for a completion, the result is 1 and the table is unchanged, whatever the operation.
- R7: A load-linked to a line that is already reserved hands the reservation to the new id. The line still occupies a single entry.
- R8: A new reservation uses a free entry if one exists. When all ENTRIES entries are valid, it replaces the valid entry that was allocated earliest. Freeing an entry does not change the relative age of the others, and a change of owner does not make an entry younger.
- R9: done_o pulses for exactly one cycle, in the cycle after each cmpl_vld_i, and success_o is valid in that cycle. After reset, done_o is 0 and no line is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_vld_i | input | 1 | Completion strobe, one cycle per operation |
| op_i | input | 2 | Operation: 0 read, 1 write, 2 load-linked, 3 store-conditional |
| line_i | input | LINE_W | Cache line address |
| req_id_i | input | ID_W | Requester id |
| tag_hit_i | input | 1 | Line tag present in the cache |
| bypass_i | input | 1 | Disable reservation processing, force success |
| done_o | output | 1 | Result valid pulse |
| success_o | output | 1 | 1 = success, 0 = failure |

## Verification
The hardest case to reach from the ports is the choice of victim when the table is full after entries have been freed out of order. The allocation ages must stay a consistent ranking through frees, reallocations and changes of owner. The stimulus fills the table, frees a middle-aged entry with a store-conditional, refills that slot and then forces one more allocation. It then probes every line with a store-conditional, which shows which reservation was dropped. The same probing reads the table state through the normal result after the write, read and bypass cases.

// File: rtl/llsc_resv_pkg.sv
package llsc_resv_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_COND  = 2'd3
  } resv_op_e;

  // store-conditional outcome: owned line means success
  function automatic logic cond_result(input logic owned);
    return owned;
  endfunction

  // plain write drops a reservation only on a present, self-owned line
  function automatic logic write_drops(input logic tag_present, input logic owned);
    return tag_present & owned;
  endfunction

  // result bit reported for any completion
  function automatic logic result_bit(input logic bypass, input resv_op_e op,
                                      input logic owned);
    if (bypass) return 1'b1;
    if (op == OP_COND) return cond_result(owned);
    return 1'b1;
  endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 8,
  parameter int ID_W    = 2
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][LINE_W-1:0] line_tab_i,
  input  logic [ENTRIES-1:0][ID_W-1:0]   owner_tab_i,
  input  logic [LINE_W-1:0]              line_i,
  input  logic [ID_W-1:0]                id_i,
  output logic [ENTRIES-1:0]             hit_o,
  output logic [ENTRIES-1:0]             own_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (line_tab_i[g] == line_i);
    assign own_o[g] = hit_o[g] && (owner_tab_i[g] == id_i);
  end
endmodule

// File: rtl/resv_victim.sv
module resv_victim #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][IDX_W-1:0] rank_i,
  output logic                          free_any_o,
  output logic [IDX_W-1:0]              slot_o
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;

  always_comb begin
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
      if (valid_i[i] && rank_i[i] == OLDEST) old_idx = IDX_W'(i);
    end
  end

  assign free_any_o = ~&valid_i;
  assign slot_o     = free_any_o ? free_idx : old_idx;
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 8,
  parameter int ID_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_vld_i,
  input  logic [1:0]        op_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              tag_hit_i,
  input  logic              bypass_i,
  output logic              done_o,
  output logic              success_o
);
  import llsc_resv_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][LINE_W-1:0] line_q, line_d;
  logic [ENTRIES-1:0][ID_W-1:0]   owner_q, owner_d;
  logic [ENTRIES-1:0][IDX_W-1:0]  rank_q, rank_d;
  logic                           done_q, succ_q;

  // named internal events, observed by the bound checker
  logic [ENTRIES-1:0] hit_vec, own_vec, valid_vec;
  logic               hit_any, own_any;
  logic [IDX_W-1:0]   hit_idx, alloc_idx;
  logic               free_any;
  logic               active, evt_lock, evt_cond, evt_write;
  logic               evt_alloc, evt_handover, evt_clear;
  resv_op_e           op;

  assign op        = resv_op_e'(op_i);
  assign valid_vec = valid_q;

  resv_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) u_match (
    .valid_i    (valid_q),
    .line_tab_i (line_q),
    .owner_tab_i(owner_q),
    .line_i     (line_i),
    .id_i       (req_id_i),
    .hit_o      (hit_vec),
    .own_o      (own_vec)
  );

  resv_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i   (valid_q),
    .rank_i    (rank_q),
    .free_any_o(free_any),
    .slot_o    (alloc_idx)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any      = |hit_vec;
  assign own_any      = |own_vec;
  assign active       = cmpl_vld_i && !bypass_i;
  assign evt_lock     = active && (op == OP_LOCK);
  assign evt_cond     = active && (op == OP_COND);
  assign evt_write    = active && (op == OP_WRITE);
  assign evt_alloc    = evt_lock && !hit_any;
  assign evt_handover = evt_lock && hit_any;
  assign evt_clear    = (evt_cond && hit_any) ||
                        (evt_write && write_drops(tag_hit_i, own_any));

  always_comb begin
    valid_d = valid_q;
    line_d  = line_q;
    owner_d = owner_q;
    rank_d  = rank_q;
    if (evt_alloc) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (valid_q[i] && IDX_W'(i) != alloc_idx) rank_d[i] = rank_q[i] + 1'b1;
      end
      valid_d[alloc_idx] = 1'b1;
      line_d[alloc_idx]  = line_i;
      owner_d[alloc_idx] = req_id_i;
      rank_d[alloc_idx]  = '0;
    end
    if (evt_handover) begin
      owner_d[hit_idx] = req_id_i;
    end
    if (evt_clear) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (valid_q[i] && rank_q[i] > rank_q[hit_idx]) rank_d[i] = rank_q[i] - 1'b1;
      end
      valid_d[hit_idx] = 1'b0;
      rank_d[hit_idx]  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      line_q  <= '0;
      owner_q <= '0;
      rank_q  <= '0;
      done_q  <= 1'b0;
      succ_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      line_q  <= line_d;
      owner_q <= owner_d;
      rank_q  <= rank_d;
      done_q  <= cmpl_vld_i;
      if (cmpl_vld_i) succ_q <= result_bit(bypass_i, op, own_any);
    end
  end

  assign done_o    = done_q;
  assign success_o = succ_q;

endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmpl_vld_i,
  input logic [1:0]         op_i,
  input logic               bypass_i,
  input logic               done_o,
  input logic               success_o,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [IDX_W-1:0]   hit_idx
);
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_vld_i |=> done_o); // R9
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmpl_vld_i |=> !done_o); // R9
  AST_LOCK_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld_i && op_i == 2'd2) |=> success_o); // R1
  AST_COND_MISS_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld_i && !bypass_i && op_i == 2'd3 && hit_vec == '0) |=> !success_o); // R2
  AST_COND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld_i && !bypass_i && op_i == 2'd3 && hit_vec != '0)
      |=> !valid_vec[$past(hit_idx)]); // R3
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld_i && op_i == 2'd0) |=> (success_o && $stable(valid_vec))); // R5
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld_i && bypass_i) |=> (success_o && $stable(valid_vec))); // R6
  AST_ONE_ENTRY_PER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7
endmodule

bind llsc_resv_monitor llsc_resv_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmpl_vld_i(cmpl_vld_i),
  .op_i      (op_i),
  .bypass_i  (bypass_i),
  .done_o    (done_o),
  .success_o (success_o),
  .hit_vec   (hit_vec),
  .valid_vec (valid_vec),
  .hit_idx   (hit_idx)
);

// File: tb/test_llsc_resv_monitor.sv
`timescale 1ns/1ps
module test_llsc_resv_monitor;
  localparam int LW = 8;
  localparam int IW = 2;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, LL = 2'd2, SC = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmpl_vld_i = 1'b0;
  logic [1:0]    op_i = 2'd0;
  logic [LW-1:0] line_i = '0;
  logic [IW-1:0] req_id_i = '0;
  logic          tag_hit_i = 1'b0;
  logic          bypass_i = 1'b0;
  logic          done_o, success_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  llsc_resv_monitor #(.ENTRIES(4), .LINE_W(LW), .ID_W(IW)) i_llsc_resv_monitor (
    .clk(clk), .rst_n(rst_n), .cmpl_vld_i(cmpl_vld_i), .op_i(op_i),
    .line_i(line_i), .req_id_i(req_id_i), .tag_hit_i(tag_hit_i),
    .bypass_i(bypass_i), .done_o(done_o), .success_o(success_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // issue one completion, then check the pulse and the result
  task automatic issue(input logic [1:0] op, input logic [LW-1:0] ln,
                       input logic [IW-1:0] id, input logic tag, input logic byp,
                       input logic exp, input string req);
    @(negedge clk);
    cmpl_vld_i = 1'b1; op_i = op; line_i = ln; req_id_i = id;
    tag_hit_i = tag; bypass_i = byp;
    @(negedge clk);
    cmpl_vld_i = 1'b0; tag_hit_i = 1'b0; bypass_i = 1'b0;
    check({req, " done"}, done_o, 1'b1);
    check(req, success_o, exp);
  endtask

  task automatic t_reset;
    check("R9 done idle after reset", done_o, 1'b0);
    issue(SC, 8'h05, 2'd0, 1'b0, 1'b0, 1'b0, "R9 empty table after reset");
    @(negedge clk);
    check("R9 single pulse", done_o, 1'b0);
  endtask

  task automatic t_lock_cond;
    issue(LL, 8'h10, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock succeeds");
    issue(SC, 8'h10, 2'd1, 1'b1, 1'b0, 1'b1, "R2 cond same owner");
    issue(SC, 8'h10, 2'd1, 1'b1, 1'b0, 1'b0, "R3 cond cleared after success");
    issue(LL, 8'h11, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(SC, 8'h11, 2'd2, 1'b1, 1'b0, 1'b0, "R2 cond other owner fails");
    issue(SC, 8'h11, 2'd1, 1'b1, 1'b0, 1'b0, "R3 failed cond also clears");
  endtask

  task automatic t_write;
    issue(LL, 8'h20, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(WR, 8'h20, 2'd1, 1'b0, 1'b0, 1'b1, "R4 write no tag reports 1");
    issue(SC, 8'h20, 2'd1, 1'b1, 1'b0, 1'b1, "R4 write without tag keeps lock");
    issue(LL, 8'h20, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(WR, 8'h20, 2'd3, 1'b1, 1'b0, 1'b1, "R4 write other id reports 1");
    issue(SC, 8'h20, 2'd1, 1'b1, 1'b0, 1'b1, "R4 write by other id keeps lock");
    issue(LL, 8'h20, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(WR, 8'h20, 2'd1, 1'b1, 1'b0, 1'b1, "R4 own write reports 1");
    issue(SC, 8'h20, 2'd1, 1'b1, 1'b0, 1'b0, "R4 own present write clears");
  endtask

  task automatic t_read;
    issue(LL, 8'h30, 2'd2, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(RD, 8'h30, 2'd2, 1'b1, 1'b0, 1'b1, "R5 read succeeds");
    issue(RD, 8'h30, 2'd0, 1'b1, 1'b0, 1'b1, "R5 read other id succeeds");
    issue(SC, 8'h30, 2'd2, 1'b1, 1'b0, 1'b1, "R5 read left lock");
  endtask

  task automatic t_handover;
    issue(LL, 8'h40, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(LL, 8'h40, 2'd2, 1'b1, 1'b0, 1'b1, "R7 relock succeeds");
    issue(SC, 8'h40, 2'd1, 1'b1, 1'b0, 1'b0, "R7 old owner lost lock");
    issue(LL, 8'h41, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(LL, 8'h41, 2'd3, 1'b1, 1'b0, 1'b1, "R7 relock");
    issue(SC, 8'h41, 2'd3, 1'b1, 1'b0, 1'b1, "R7 new owner holds lock");
    issue(SC, 8'h41, 2'd3, 1'b1, 1'b0, 1'b0, "R7 single entry for line");
  endtask

  task automatic t_replace;
    // fill: ages 50 oldest .. 53 youngest
    for (int k = 0; k < 4; k++)
      issue(LL, 8'h50 + 8'(k), 2'd1, 1'b1, 1'b0, 1'b1, "R8 fill");
    issue(LL, 8'h54, 2'd1, 1'b1, 1'b0, 1'b1, "R8 lock into full table");
    issue(SC, 8'h50, 2'd1, 1'b1, 1'b0, 1'b0, "R8 oldest evicted");
    // table now 51,52,53,54 ; free 52, refill with 55, relock 51 (no age change)
    issue(SC, 8'h52, 2'd1, 1'b1, 1'b0, 1'b1, "R8 free middle entry");
    issue(LL, 8'h55, 2'd1, 1'b1, 1'b0, 1'b1, "R8 reuse free slot");
    issue(LL, 8'h51, 2'd2, 1'b1, 1'b0, 1'b1, "R8 owner change");
    issue(LL, 8'h56, 2'd1, 1'b1, 1'b0, 1'b1, "R8 lock into full table");
    issue(SC, 8'h51, 2'd2, 1'b1, 1'b0, 1'b0, "R8 oldest after frees evicted");
    issue(SC, 8'h53, 2'd1, 1'b1, 1'b0, 1'b1, "R8 survivor 53");
    issue(SC, 8'h54, 2'd1, 1'b1, 1'b0, 1'b1, "R8 survivor 54");
    issue(SC, 8'h55, 2'd1, 1'b1, 1'b0, 1'b1, "R8 survivor 55");
    issue(SC, 8'h56, 2'd1, 1'b1, 1'b0, 1'b1, "R8 survivor 56");
  endtask

  task automatic t_bypass;
    issue(LL, 8'h60, 2'd1, 1'b1, 1'b0, 1'b1, "R1 lock");
    issue(SC, 8'h60, 2'd2, 1'b1, 1'b1, 1'b1, "R6 bypassed cond succeeds");
    issue(WR, 8'h60, 2'd1, 1'b1, 1'b1, 1'b1, "R6 bypassed write");
    issue(SC, 8'h60, 2'd1, 1'b1, 1'b0, 1'b1, "R6 lock untouched by bypass");
    issue(LL, 8'h61, 2'd1, 1'b1, 1'b1, 1'b1, "R6 bypassed lock");
    issue(SC, 8'h61, 2'd1, 1'b1, 1'b0, 1'b0, "R6 bypassed lock set nothing");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock_cond();
    t_write();
    t_read();
    t_handover();
    t_replace();
    t_bypass();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule